// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a free-standing watchdog. Software controls it entirely through 16-bit magic values written to a command slot. One value opens the prescaler and timeout registers for writing. One starts the countdown. One refreshes the countdown. Every other value closes the configuration registers again.

Once started, a 12-bit down-counter runs from a prescaled tick. If software does not refresh the counter in time, the block raises a one-cycle reset request and reloads the counter. Nothing short of the block's own reset stops it.

Configuration writes land first in a visible holding copy. They take effect only after a fixed number of prescaled ticks. A status word reports while each update is still in flight. This models the delay of carrying the setting into a slow clock domain.

Top module: `key_watchdog`

## Requirements
- R1: After reset `rst_req` is low. The command slot (offset 0x0) reads 0, the prescaler (offset 0x4) reads 0 and the timeout (offset 0x8) reads 0xFFF. The status word (offset 0xC, bit 0 = prescaler update pending, bit 1 = timeout update pending) reads 0.
- R2: A write to offset 0x4 or 0x8 is ignored unless the most recent value written to offset 0x0 was 0x5555. Writing any other value to offset 0x0 closes access again.
- R3: An accepted write to offset 0x4 or 0x8 reads back at once from that offset. Its status bit (bit 0 for 0x4, bit 1 for 0x8) reads 1 from the next cycle.
- R4: A pending status bit clears on the 2nd prescaled tick after the write. It therefore reads 1 for between div+1 and 2·div cycles, and at that point the new value becomes active.
- R5: Until 0xCCCC has been written to offset 0x0, `rst_req` never rises.
- R6: Writing 0xCCCC starts the countdown from timeout value r. The first request is registered between r·div+1 and (r+1)·div cycles after the write edge.
- R7: While the watchdog runs unrefreshed, consecutive requests are exactly (r+1)·div cycles apart. Here div = 2^(p+2) for prescaler code p of 0 to 5, and div = 256 for codes 6 and 7.
- R8: Writing 0xAAAA reloads the counter with r. Refreshes spaced closer than r·div+1 cycles keep `rst_req` low. After the last refresh the request comes within (r+1)·div cycles.
- R9: Once running, no write to offset 0x0 stops the watchdog. This includes 0x0000, arbitrary values and a second 0xCCCC. Requests continue with the R7 spacing.
- R10: Each request holds `rst_req` high for exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte offset of the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Byte offset of the combinational read |
| rd_data | output | DATA_W | Read data for `rd_addr` |
| rst_req | output | 1 | One-cycle reset request on expiry |

## Verification
A wrong lock state shows up at the very next readback of the prescaler or timeout offset: a value that should have been refused appears, or an accepted one is missing. A stuck or mistimed pending flag shows in the status word within two prescaled ticks of the write. A counter or prescaler that miscounts shows in the spacing of `rst_req` pulses within one timeout period. The bench therefore sweeps every prescaler code against several timeout values and compares the pulse interval with the product computed from the requirement.

// File: rtl/kwd_pkg.sv
package kwd_pkg;
  localparam logic [15:0] KEY_OPEN    = 16'h5555;
  localparam logic [15:0] KEY_START   = 16'hCCCC;
  localparam logic [15:0] KEY_REFRESH = 16'hAAAA;

  typedef enum logic [1:0] {
    SLOT_CMD  = 2'd0,
    SLOT_PSC  = 2'd1,
    SLOT_TMO  = 2'd2,
    SLOT_STAT = 2'd3
  } slot_e;

  // Word-aligned offset match: offset = 4 * slot, all other bits zero.
  function automatic logic offset_hit(input logic [31:0] addr, input slot_e slot);
    return addr == (32'(slot) << 2);
  endfunction

  // log2 of the prescale divisor for a code, saturating at hi.
  function automatic int unsigned div_log2(input int unsigned code,
                                           input int unsigned lo,
                                           input int unsigned hi);
    return (code + lo > hi) ? hi : code + lo;
  endfunction
endpackage

// File: rtl/kwd_regs.sv
module kwd_regs import kwd_pkg::*; #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              psc_try,
  output logic              tmo_try,
  output logic              psc_load,
  output logic              tmo_load,
  output logic              start_ev,
  output logic              refresh_ev,
  output logic              open_q
);
  logic cmd_hit;

  always_comb begin
    cmd_hit    = wr_en && offset_hit(32'(wr_addr), SLOT_CMD);
    psc_try    = wr_en && offset_hit(32'(wr_addr), SLOT_PSC);
    tmo_try    = wr_en && offset_hit(32'(wr_addr), SLOT_TMO);
    psc_load   = psc_try && open_q;
    tmo_load   = tmo_try && open_q;
    start_ev   = cmd_hit && (wr_data == KEY_START);
    refresh_ev = cmd_hit && (wr_data == KEY_REFRESH);
  end

  // Access stays open only while the last command was the open key.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       open_q <= 1'b0;
    else if (cmd_hit) open_q <= (wr_data == KEY_OPEN);
  end

  // R2
  relock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && wr_data != KEY_OPEN) |=> !open_q);
endmodule

// File: rtl/kwd_update_slot.sv
module kwd_update_slot #(
  parameter int          W         = 12,
  parameter logic [W-1:0] RESET_VAL = '1,
  parameter int          UPD_TICKS = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] shadow,
  output logic [W-1:0] active,
  output logic         busy
);
  localparam int LW = $clog2(UPD_TICKS + 1);
  logic [LW-1:0] left;
  logic          commit;

  assign commit = busy && tick && (left == LW'(1)) && !load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= RESET_VAL;
      active <= RESET_VAL;
      busy   <= 1'b0;
      left   <= '0;
    end else if (load) begin
      shadow <= load_val;
      busy   <= 1'b1;
      left   <= LW'(UPD_TICKS);
    end else if (commit) begin
      active <= shadow;
      busy   <= 1'b0;
      left   <= '0;
    end else if (busy && tick) begin
      left   <= left - LW'(1);
    end
  end

  // R3
  load_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (busy && shadow == $past(load_val)));
  // R4
  commit_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (active == shadow));
  // R4
  idle_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load) |=> $stable(active));
endmodule

// File: rtl/kwd_prescaler.sv
module kwd_prescaler import kwd_pkg::*; #(
  parameter int PSC_W    = 3,
  parameter int MIN_LOG2 = 2,
  parameter int MAX_LOG2 = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] code,
  output logic             tick
);
  localparam int CW = MAX_LOG2;
  logic [CW-1:0] count;
  logic [CW:0]   lim_wide;
  logic [CW-1:0] limit;

  always_comb begin
    lim_wide = ((CW+1)'(1) << div_log2(int'(code), MIN_LOG2, MAX_LOG2)) - (CW+1)'(1);
    limit    = lim_wide[CW-1:0];
    // ">=" absorbs a divisor shrink that leaves count beyond the new limit
    tick     = (count >= limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (tick) count <= '0;
    else           count <= count + CW'(1);
  end

  // R7
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/kwd_counter.sv
module kwd_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start_ev,
  input  logic             refresh_ev,
  input  logic [CNT_W-1:0] reload_val,
  output logic             running,
  output logic             expire,
  output logic             rst_req
);
  logic [CNT_W-1:0] cnt;

  assign expire = running && tick && (cnt == '0) && !refresh_ev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '1;
      rst_req <= 1'b0;
    end else begin
      rst_req <= expire;
      if (!running) begin
        if (start_ev) begin
          running <= 1'b1;
          cnt     <= reload_val;
        end
      end else if (refresh_ev) begin
        cnt <= reload_val;
      end else if (tick) begin
        if (cnt == '0) cnt <= reload_val;
        else           cnt <= cnt - CNT_W'(1);
      end
    end
  end

  // R9
  sticky_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> running);
  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> running);
  // R10
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  // R7
  reload_after_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (cnt == $past(reload_val)));
endmodule

// File: rtl/key_watchdog.sv
module key_watchdog import kwd_pkg::*; #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 12,
  parameter int PSC_W     = 3,
  parameter int MIN_LOG2  = 2,
  parameter int MAX_LOG2  = 8,
  parameter int UPD_TICKS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rst_req
);
  logic psc_try, tmo_try, psc_load, tmo_load;
  logic start_ev, refresh_ev, open_q;
  logic tick, running, expire;
  logic psc_busy, tmo_busy;
  logic [PSC_W-1:0] psc_shadow, psc_active;
  logic [CNT_W-1:0] tmo_shadow, tmo_active;

  kwd_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .psc_try(psc_try), .tmo_try(tmo_try), .psc_load(psc_load), .tmo_load(tmo_load),
    .start_ev(start_ev), .refresh_ev(refresh_ev), .open_q(open_q));

  kwd_update_slot #(.W(PSC_W), .RESET_VAL('0), .UPD_TICKS(UPD_TICKS)) u_psc_slot (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(psc_load),
    .load_val(wr_data[PSC_W-1:0]), .shadow(psc_shadow), .active(psc_active),
    .busy(psc_busy));

  kwd_update_slot #(.W(CNT_W), .RESET_VAL('1), .UPD_TICKS(UPD_TICKS)) u_tmo_slot (
    .clk(clk), .rst_n(rst_n), .tick(tick), .load(tmo_load),
    .load_val(wr_data[CNT_W-1:0]), .shadow(tmo_shadow), .active(tmo_active),
    .busy(tmo_busy));

  kwd_prescaler #(.PSC_W(PSC_W), .MIN_LOG2(MIN_LOG2), .MAX_LOG2(MAX_LOG2)) u_psc (
    .clk(clk), .rst_n(rst_n), .code(psc_active), .tick(tick));

  kwd_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start_ev(start_ev),
    .refresh_ev(refresh_ev), .reload_val(tmo_active), .running(running),
    .expire(expire), .rst_req(rst_req));

  always_comb begin
    rd_data = '0;
    if (offset_hit(32'(rd_addr), SLOT_PSC))       rd_data = DATA_W'(psc_shadow);
    else if (offset_hit(32'(rd_addr), SLOT_TMO))  rd_data = DATA_W'(tmo_shadow);
    else if (offset_hit(32'(rd_addr), SLOT_STAT)) rd_data = DATA_W'({tmo_busy, psc_busy});
  end

  // R2
  locked_psc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (psc_try && !open_q) |=> $stable(psc_shadow));
  // R2
  locked_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_try && !open_q) |=> $stable(tmo_shadow));
  // R8
  refresh_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (running && refresh_ev) |=> !rst_req);
endmodule

// File: tb/tb_key_watchdog.sv
`timescale 1ns/1ps
module tb_key_watchdog;
  localparam int UPD = 2;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        rst_req;

  key_watchdog dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .rst_req(rst_req));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0, pulse_cnt = 0, last_pulse = 0, wide_cnt = 0;
  bit prev_hi = 0, finished = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rst_req) begin
        pulse_cnt++;
        last_pulse = cyc;
        if (prev_hi) wide_cnt++;
      end
      prev_hi = rst_req;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output int v);
    rd_addr = a; #1; v = int'(rd_data);
  endtask

  function automatic int div_of(input int code);
    return (code >= 6) ? 256 : (4 << code);
  endfunction

  task automatic snap(output int s);
    #2; s = pulse_cnt;
  endtask

  task automatic wait_pulse(input int s, output int c);
    int guard = 0;
    while (pulse_cnt == s && guard < 5000) begin @(negedge clk); #2; guard++; end
    c = last_pulse;
  endtask

  task automatic wait_status_clear();
    int v, guard = 0;
    rd(4'hC, v);
    while (v != 0 && guard < 2000) begin @(negedge clk); rd(4'hC, v); guard++; end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int v, n, s, a, b, c, t0, r, dv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(rst_req == 1'b0, "R1 rst_req", int'(rst_req), 0);
    rd(4'h0, v); check(v == 0, "R1 cmd read", v, 0);
    rd(4'h4, v); check(v == 0, "R1 prescaler", v, 0);
    rd(4'h8, v); check(v == 12'hFFF, "R1 timeout", v, 12'hFFF);
    rd(4'hC, v); check(v == 0, "R1 status", v, 0);

    // R2 locked writes ignored
    wr(4'h4, 16'd5);
    rd(4'h4, v); check(v == 0, "R2 locked prescaler", v, 0);
    rd(4'hC, v); check(v == 0, "R2 locked status", v, 0);
    wr(4'h0, 16'h5555); wr(4'h0, 16'h1234); wr(4'h8, 16'd7);
    rd(4'h8, v); check(v == 12'hFFF, "R2 relocked timeout", v, 12'hFFF);
    wr(4'h0, 16'h5555); wr(4'h0, 16'hAAAA); wr(4'h4, 16'd3);
    rd(4'h4, v); check(v == 0, "R2 refresh key relocks", v, 0);

    // R3 accepted write, R4 busy window at div 4
    wr(4'h0, 16'h5555); wr(4'h8, 16'd3);
    rd(4'h8, v); check(v == 3, "R3 timeout readback", v, 3);
    rd(4'hC, v); check((v & 2) != 0, "R3 timeout pending bit1", v & 2, 2);
    n = 0;
    while ((v & 2) != 0 && n < 100) begin n++; @(negedge clk); rd(4'hC, v); end
    check(n >= (UPD-1)*4 + 1 && n <= UPD*4, "R4 timeout pending span", n, UPD*4);
    wr(4'h4, 16'd0);
    rd(4'hC, v); check(v == 1, "R3 prescaler pending bit0", v, 1);
    n = 0;
    while ((v & 1) != 0 && n < 100) begin n++; @(negedge clk); rd(4'hC, v); end
    check(n >= (UPD-1)*4 + 1 && n <= UPD*4, "R4 prescaler pending span", n, UPD*4);

    // R5 idle: no request
    snap(s);
    repeat (300) @(negedge clk);
    #2; check(pulse_cnt == s, "R5 idle pulses", pulse_cnt - s, 0);

    // R6 first expiry after start, r=3 div=4
    wr(4'h0, 16'hCCCC); t0 = cyc; snap(s);
    wait_pulse(s, c);
    check(c - t0 >= 13 && c - t0 <= 16, "R6 first expiry delay", c - t0, 16);
    // R10 single-cycle pulse
    check(rst_req == 1'b1, "R10 pulse high", int'(rst_req), 1);
    @(negedge clk); #2;
    check(rst_req == 1'b0, "R10 pulse drops", int'(rst_req), 0);

    // R9 cannot be stopped
    wr(4'h0, 16'h0000); wr(4'h0, 16'h1234); wr(4'h0, 16'hCCCC);
    snap(s); wait_pulse(s, a); snap(s); wait_pulse(s, b);
    check(b - a == 16, "R9 still running period", b - a, 16);

    // R8 refresh keeps request low
    wr(4'h0, 16'hAAAA); snap(s);
    for (int k = 0; k < 25; k++) begin
      repeat (6) @(negedge clk);
      wr(4'h0, 16'hAAAA);
    end
    t0 = cyc; #2;
    check(pulse_cnt == s, "R8 refreshed pulses", pulse_cnt - s, 0);
    wait_pulse(s, c);
    check(c - t0 >= 13 && c - t0 <= 16, "R8 expiry after last refresh", c - t0, 16);

    // R7 sweep of prescaler codes and timeout values
    for (int code = 0; code < 8; code++) begin
      for (int ri = 0; ri < 4; ri++) begin
        r = (ri == 3) ? 5 : ri;
        dv = div_of(code);
        wr(4'h0, 16'h5555); wr(4'h4, 16'(code)); wr(4'h8, 16'(r));
        wait_status_clear();
        snap(s); wait_pulse(s, a);
        snap(s); wait_pulse(s, b);
        snap(s); wait_pulse(s, c);
        check(c - b == (r+1)*dv, $sformatf("R7 period code=%0d r=%0d", code, r),
              c - b, (r+1)*dv);
      end
    end

    // R10 no wide pulse seen over the whole run
    check(wide_cnt == 0, "R10 wide pulses", wide_cnt, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule